// File: doc/BRIEF.md
# Erased Sector Zero-Bit Counter

This block decides whether a flash sector that the main error decoder could not repair is in fact an erased sector with a few flipped bits. Erased cells read as ones. The stored check bytes of an erased sector are also all ones, but that is not a valid codeword, so the decoder reports too many errors. The block takes the sector as a byte stream. A sector holds 512 data bytes and then 13 check bytes. For each byte the block adds the number of its zero bits to a running count. The data part and the check part each have their own count.

Each count stops growing at one above the correction limit of 8, because a sector past that point cannot qualify. On the cycle after the final byte, the block presents one registered result. The result holds the summed count, an erased verdict, an uncorrectable verdict, a request to overwrite the data part with all ones, and a framing error for a sector of the wrong length. The verdict applies only when the decoder's error count, sampled with the final byte, is above the limit. A new sector may begin on the cycle after the final byte.

Top module: `erased_sector_scan`

## Requirements
- R1: A synchronous active-high reset clears every output to 0, and in the cycle after a reset edge `res_valid` is 0.
- R2: Each accepted data byte (stream positions 0 to 511) adds the number of 0 bits in that byte to a data count. The data count saturates at 9. `res_flips` reports the data count plus the check count.
- R3: Each accepted check byte (positions 512 to 524) adds its number of 0 bits to a separate check count, which also saturates at 9. Bytes at position 525 and later add to neither count.
- R4: For an active, correctly framed sector whose summed count is 8 or less, `res_erased` is 1.
- R5: For an active, correctly framed sector whose summed count is above 8, `res_uncorr` is 1. `res_erased` and `res_uncorr` are never both 1.
- R6: `res_fill` is 1 exactly when `res_erased` is 1 and the data count is nonzero.
- R7: A sector is active only when `dec_err_cnt` is greater than 8 on the final byte. For an inactive sector, `res_erased`, `res_uncorr`, `res_fill` and `res_flips` are all 0.
- R8: A cycle with `in_valid` low changes no count and produces no result, whatever `in_data` and `in_last` hold.
- R9: If the final byte is not at position 524, `res_frame_err` is 1 and `res_erased`, `res_uncorr` and `res_fill` are 0.
- R10: `res_valid` is 1 for exactly the one cycle after a byte is accepted with `in_last` high. Both counts start from zero for the next byte, so sectors can follow each other with no idle cycle between them.
- R11: A reset in the middle of a sector discards the partial counts and the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Sector byte |
| in_last | input | 1 | Marks the final byte of a sector |
| dec_err_cnt | input | 4 | Decoder error count, sampled with the final byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_flips | output | 5 | Saturated data count plus saturated check count |
| res_erased | output | 1 | Sector is erased with few flips |
| res_uncorr | output | 1 | Sector cannot be treated as erased |
| res_fill | output | 1 | Data part must be overwritten with 0xFF |
| res_frame_err | output | 1 | Final byte arrived at the wrong position |

## Verification
Two things can happen in the same cycle: the final byte's own zero bits are added to a count, and the counts are cleared for the next sector. The bench provokes this by placing the deciding flips in the final check byte and in the byte just before it, and by sending sectors back to back. Those cases show whether the verdict includes the last byte and whether the next sector starts from zero. A behavioural model in the bench keeps integer counts. Every clock, the bench compares all outputs with that model, including the cycles where `in_valid` is low and `in_data` and `in_last` carry values meant to mislead.

// File: rtl/ersc_pkg.sv
package ersc_pkg;
  // Region of the sector that the current byte position falls into
  typedef enum logic [1:0] {
    PART_DATA  = 2'd0,
    PART_CHECK = 2'd1,
    PART_OVER  = 2'd2
  } part_e;
endpackage

// File: rtl/ersc_zero_count.sv
module ersc_zero_count #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  byte_i,
  output logic [CW-1:0] zeros_o
);
  logic [W-1:0] is_zero;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign is_zero[g] = ~byte_i[g];
    end
  endgenerate

  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < W; i++) begin
      zeros_o = zeros_o + CW'(is_zero[i]);
    end
  end
endmodule

// File: rtl/ersc_sat_acc.sv
module ersc_sat_acc #(
  parameter int INC_W = 4,
  parameter int CAP   = 9,
  localparam int ACC_W = $clog2(CAP + 1),
  localparam int SW    = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [INC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_next,
  output logic [ACC_W-1:0] acc_q
);
  logic [SW-1:0] wide_sum;

  always_comb begin
    wide_sum = SW'(acc_q) + SW'(inc);
    if (!add_en) begin
      acc_next = acc_q;
    end else if (wide_sum >= SW'(CAP)) begin
      acc_next = ACC_W'(CAP);
    end else begin
      acc_next = ACC_W'(wide_sum);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/ersc_position.sv
module ersc_position
  import ersc_pkg::*;
#(
  parameter int DATA_BYTES  = 512,
  parameter int CHECK_BYTES = 13,
  localparam int TOTAL = DATA_BYTES + CHECK_BYTES,
  localparam int PW    = $clog2(TOTAL + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  logic  done,
  output part_e part_o,
  output logic  at_end_o
);
  logic [PW-1:0] pos_q;

  always_comb begin
    if (pos_q < PW'(DATA_BYTES)) begin
      part_o = PART_DATA;
    end else if (pos_q < PW'(TOTAL)) begin
      part_o = PART_CHECK;
    end else begin
      part_o = PART_OVER;
    end
  end

  assign at_end_o = (pos_q == PW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst || (step && done)) begin
      pos_q <= '0;
    end else if (step && (pos_q != PW'(TOTAL))) begin
      pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/erased_sector_scan.sv
module erased_sector_scan
  import ersc_pkg::*;
#(
  parameter int DATA_BYTES  = 512,
  parameter int CHECK_BYTES = 13,
  parameter int LIMIT       = 8,
  parameter int BYTE_W      = 8,
  parameter int ERR_W       = 4,
  localparam int CAP   = LIMIT + 1,
  localparam int SUM_W = $clog2(2 * CAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic [ERR_W-1:0]  dec_err_cnt,
  output logic              res_valid,
  output logic [SUM_W-1:0]  res_flips,
  output logic              res_erased,
  output logic              res_uncorr,
  output logic              res_fill,
  output logic              res_frame_err
);
  localparam int INC_W = $clog2(BYTE_W + 1);
  localparam int ACC_W = $clog2(CAP + 1);

  logic [INC_W-1:0] zeros;
  logic [ACC_W-1:0] data_next, data_q;
  logic [ACC_W-1:0] chk_next, chk_q;
  logic [SUM_W-1:0] sum_next;
  part_e            part;
  logic             at_end;
  logic             end_evt;
  logic             active;
  logic             qualifies;

  assign end_evt = in_valid && in_last;
  assign active  = (dec_err_cnt > ERR_W'(LIMIT));

  ersc_zero_count #(.W(BYTE_W)) u_zero (
    .byte_i  (in_data),
    .zeros_o (zeros)
  );

  ersc_position #(
    .DATA_BYTES  (DATA_BYTES),
    .CHECK_BYTES (CHECK_BYTES)
  ) u_pos (
    .clk      (clk),
    .rst      (rst),
    .step     (in_valid),
    .done     (in_last),
    .part_o   (part),
    .at_end_o (at_end)
  );

  ersc_sat_acc #(.INC_W(INC_W), .CAP(CAP)) u_data_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (end_evt),
    .add_en   (in_valid && (part == PART_DATA)),
    .inc      (zeros),
    .acc_next (data_next),
    .acc_q    (data_q)
  );

  ersc_sat_acc #(.INC_W(INC_W), .CAP(CAP)) u_chk_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (end_evt),
    .add_en   (in_valid && (part == PART_CHECK)),
    .inc      (zeros),
    .acc_next (chk_next),
    .acc_q    (chk_q)
  );

  assign sum_next  = SUM_W'(data_next) + SUM_W'(chk_next);
  assign qualifies = end_evt && active && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_flips     <= '0;
      res_erased    <= 1'b0;
      res_uncorr    <= 1'b0;
      res_fill      <= 1'b0;
      res_frame_err <= 1'b0;
    end else begin
      res_valid     <= end_evt;
      res_flips     <= (end_evt && active) ? sum_next : '0;
      res_erased    <= qualifies && (sum_next <= SUM_W'(LIMIT));
      res_uncorr    <= qualifies && (sum_next > SUM_W'(LIMIT));
      res_fill      <= qualifies && (sum_next <= SUM_W'(LIMIT)) && (data_next != '0);
      res_frame_err <= end_evt && !at_end;
    end
  end
endmodule

// File: rtl/ersc_checker.sv
module ersc_checker #(
  parameter int LIMIT = 8,
  parameter int ERR_W = 4,
  parameter int SUM_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic [ERR_W-1:0] dec_err_cnt,
  input logic             res_valid,
  input logic [SUM_W-1:0] res_flips,
  input logic             res_erased,
  input logic             res_uncorr,
  input logic             res_fill,
  input logic             res_frame_err
);
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !res_valid);

  p_erased_bound_r4: assert property (@(posedge clk) disable iff (rst)
    res_erased |-> (res_flips <= SUM_W'(LIMIT)));

  p_uncorr_bound_r5: assert property (@(posedge clk) disable iff (rst)
    res_uncorr |-> (res_flips > SUM_W'(LIMIT)));

  p_one_verdict_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_erased, res_uncorr, res_frame_err}));

  p_fill_needs_erased_r6: assert property (@(posedge clk) disable iff (rst)
    res_fill |-> res_erased);

  p_inactive_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && (dec_err_cnt <= ERR_W'(LIMIT)))
      |=> (!res_erased && !res_uncorr && !res_fill && (res_flips == '0)));

  p_no_result_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_last) |=> !res_valid);

  p_valid_after_last_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> res_valid);

  p_flags_need_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_erased && !res_uncorr && !res_fill && !res_frame_err));
endmodule

bind erased_sector_scan ersc_checker #(
  .LIMIT (LIMIT),
  .ERR_W (ERR_W),
  .SUM_W (SUM_W)
) u_ersc_checker (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_last       (in_last),
  .dec_err_cnt   (dec_err_cnt),
  .res_valid     (res_valid),
  .res_flips     (res_flips),
  .res_erased    (res_erased),
  .res_uncorr    (res_uncorr),
  .res_fill      (res_fill),
  .res_frame_err (res_frame_err)
);

// File: tb/erased_sector_scan_bench.sv
module erased_sector_scan_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic [3:0] dec_err_cnt = 4'd0;
  logic       res_valid;
  logic [4:0] res_flips;
  logic       res_erased, res_uncorr, res_fill, res_frame_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R1 reset";
  logic [7:0] sec[$];

  // reference model state
  int m_pos = 0, m_d = 0, m_c = 0;
  int e_valid = 0, e_flips = 0, e_erased = 0, e_uncorr = 0, e_fill = 0, e_frame = 0;

  always #2 clk = ~clk;

  erased_sector_scan u_erased_sector_scan (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
    .in_last (in_last), .dec_err_cnt (dec_err_cnt), .res_valid (res_valid),
    .res_flips (res_flips), .res_erased (res_erased), .res_uncorr (res_uncorr),
    .res_fill (res_fill), .res_frame_err (res_frame_err)
  );

  always @(posedge clk) begin
    int z, sum, act;
    cycles++;
    e_valid = 0; e_flips = 0; e_erased = 0; e_uncorr = 0; e_fill = 0; e_frame = 0;
    if (rst) begin
      m_pos = 0; m_d = 0; m_c = 0;
    end else if (in_valid) begin
      z = $countones(~in_data);
      if (m_pos < 512) m_d = (m_d + z > 9) ? 9 : m_d + z;
      else if (m_pos < 525) m_c = (m_c + z > 9) ? 9 : m_c + z;
      if (in_last) begin
        sum = m_d + m_c;
        act = (dec_err_cnt > 8) ? 1 : 0;
        e_valid = 1;
        e_frame = (m_pos != 524) ? 1 : 0;
        e_flips = act ? sum : 0;
        e_erased = (act && !e_frame && sum <= 8) ? 1 : 0;
        e_uncorr = (act && !e_frame && sum > 8) ? 1 : 0;
        e_fill = (e_erased && m_d != 0) ? 1 : 0;
        m_pos = 0; m_d = 0; m_c = 0;
      end else begin
        m_pos++;
      end
    end
  end

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] act=%0d exp=%0d at cycle %0d", req, phase, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cmp("R10 valid", int'(res_valid), e_valid);
    cmp("R2 flips", int'(res_flips), e_flips);
    cmp("R4 erased", int'(res_erased), e_erased);
    cmp("R5 uncorr", int'(res_uncorr), e_uncorr);
    cmp("R6 fill", int'(res_fill), e_fill);
    cmp("R9 frame", int'(res_frame_err), e_frame);
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog act=%0d exp=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic build(int df, int cf);
    logic [7:0] t;
    sec.delete();
    for (int i = 0; i < 525; i++) sec.push_back(8'hFF);
    for (int k = 0; k < df; k++) begin
      t = sec[(k * 37) % 512]; t[k % 8] = 1'b0; sec[(k * 37) % 512] = t;
    end
    for (int k = 0; k < cf; k++) begin
      t = sec[524 - (k % 13)]; t[(k * 3) % 8] = 1'b0; sec[524 - (k % 13)] = t;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_data = 8'h00; in_last = 1'b1;
    end
  endtask

  task automatic drive(int errs, int gap, int nmax);
    int n;
    n = (nmax < 0) ? sec.size() : nmax;
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) idle(1);
      @(negedge clk);
      in_valid = 1'b1; in_data = sec[i];
      in_last = (i == sec.size() - 1); dec_err_cnt = 4'(errs);
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(3);
    phase = "R4 clean sector";          build(0, 0);  drive(15, 0, -1); idle(2);
    phase = "R6 flips in data and check"; build(3, 2); drive(9, 0, -1); idle(2);
    phase = "R3 flips only in check";   build(0, 4);  drive(12, 0, -1); idle(2);
    phase = "R4 boundary eight";        build(5, 3);  drive(9, 0, -1); idle(2);
    phase = "R5 boundary nine";         build(6, 3);  drive(9, 0, -1); idle(2);
    phase = "R2 data saturation";       build(12, 0); drive(10, 0, -1); idle(2);
    phase = "R3 check saturation";      build(0, 12); drive(10, 0, -1); idle(2);
    phase = "R5 random content";
    sec.delete();
    for (int i = 0; i < 525; i++) sec.push_back(8'($urandom));
    drive(13, 0, -1); idle(2);
    phase = "R7 decoder at limit";      build(2, 1);  drive(8, 0, -1); idle(2);
    phase = "R8 gaps in stream";        build(4, 1);  drive(9, 7, -1); idle(2);
    phase = "R9 short frame";           build(1, 0);  void'(sec.pop_back()); drive(9, 0, -1); idle(2);
    phase = "R9 long frame";            build(1, 0);  sec.push_back(8'h00); drive(9, 0, -1); idle(2);
    phase = "R10 back to back";
    build(7, 2); drive(9, 0, -1);
    build(0, 1); drive(9, 0, -1);
    build(3, 0); drive(2, 0, -1); idle(2);
    phase = "R11 reset mid sector";
    build(10, 0); drive(9, 0, 200);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    build(0, 0); drive(9, 0, -1); idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule